// File: doc/BRIEF.md
# Open-Row-Aware Command Picker with Age Promotion

This block chooses which queued memory command goes next to the SDRAM command sequencer. It looks at every occupied slot of a shared multi-master command queue. Each slot carries the issuing master, a 3-bit priority, the transfer direction, a bank and a row. The block also receives, for every bank, whether a row is open and which row that is. From all of this it produces, in the same cycle, the slot index of the chosen command. Commands that land in an already-open row are favoured, so activate and precharge overhead stays hidden behind useful transfers.

Each master contributes only its oldest queued command. Slot 0 is the oldest in the queue and age grows toward slot 0, so commands from one master leave in order. Among these candidates, a row hit wins over a row miss whatever the priorities. Within the winning group the smallest priority value wins, and the older slot breaks a tie. A counter of accepted transfers protects against starvation. Once the counter reaches a programmable limit, the oldest command in the whole queue is chosen regardless of row state or priority, until that command has been accepted.

The sequencer pulses `issue` in a cycle where it takes the currently selected command. The queue is expected to retire and compact that slot before the next cycle.

Top module: `row_sched`

## Requirements
- R1: `sel_valid` is 1 exactly when at least one bit of `ent_valid` is set. While reset is held and the queue is empty, `sel_valid` is 0.
- R2: A slot is a candidate only when it is valid and no lower-numbered valid slot has the same master ID. Only candidates are selected outside promotion.
- R3: A slot hits when `bank_open[bank]` is 1 and the open row of that bank equals the slot's row. If any candidate hits, the selected slot is a hit, for reads and writes alike.
- R4: Among hitting candidates, the slot with the numerically smallest priority (0 is highest) is chosen; equal priorities go to the lower slot index.
- R5: If no candidate hits, the candidate with the smallest priority value is chosen; equal priorities go to the lower slot index.
- R6: An internal count rises by one for each cycle with `issue` and `sel_valid` both 1, and saturates at `promo_limit`. When the count equals or exceeds a nonzero `promo_limit` and a slot is valid, the lowest-numbered valid slot is selected and `sel_promoted` is 1.
- R7: Accepting a promoted command (`issue` while `sel_promoted`) clears the count to 0, so the following cycle is not promoted.
- R8: A `promo_limit` of 0 disables promotion: `sel_promoted` stays 0 and the count is held at 0.
- R9: `sel_write` carries the direction bit of the selected slot (1 = write), and `sel_hit` is 1 when the selected slot hits an open row by the rule of R3.
- R10: A synchronous active-high `rst` clears the count, so no promotion occurs in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | N_SLOT | Slot occupied; slot 0 is the oldest |
| ent_master | input | N_SLOT*MID_W | Master ID per slot, slot i at bits [i*MID_W +: MID_W] |
| ent_prio | input | N_SLOT*3 | Priority per slot, 0 highest |
| ent_write | input | N_SLOT | Direction per slot, 1 = write |
| ent_bank | input | N_SLOT*BANK_W | Bank per slot |
| ent_row | input | N_SLOT*ROW_W | Row per slot |
| bank_open | input | N_BANK | A row is open in this bank |
| bank_row | input | N_BANK*ROW_W | Open row per bank |
| issue | input | 1 | Sequencer accepts the selected command this cycle |
| promo_limit | input | CNT_W | Accepted transfers before promotion; 0 disables |
| sel_valid | output | 1 | A command is selected |
| sel_idx | output | IDX_W | Slot index of the selected command |
| sel_write | output | 1 | Direction of the selected command |
| sel_hit | output | 1 | Selected command hits an open row |
| sel_promoted | output | 1 | Selection is a forced promotion of the oldest slot |

## Verification
The hardest state to reach is a promotion that overrides a competing row hit. It needs a low-priority row miss sitting in slot 0 while the accepted-transfer count climbs to the limit, followed by an acceptance that must clear the count. A directed sequence builds exactly that queue and pulses `issue` across the boundary. Long random phases then run with limits of 1, 3 and 7 and with promotion disabled. Narrow row and bank ranges in those phases keep hits, same-master shadowing and priority ties frequent.

// File: rtl/row_sched_pkg.sv
package row_sched_pkg;

    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_AGED,
        PICK_HIT,
        PICK_PRIO
    } pick_e;

    // a outranks b when its priority value is strictly smaller
    function automatic logic prio_beats(input prio_t a, input prio_t b);
        return a < b;
    endfunction

endpackage

// File: rtl/row_sched_nominate.sv
module row_sched_nominate #(
    parameter int N_SLOT = 8,
    parameter int MID_W  = 2
) (
    input  logic [N_SLOT-1:0]       valid,
    input  logic [N_SLOT*MID_W-1:0] master,
    output logic [N_SLOT-1:0]       nom
);

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        logic shadowed;
        always_comb begin
            shadowed = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (valid[j] && (master[j*MID_W +: MID_W] == master[i*MID_W +: MID_W]))
                    shadowed = 1'b1;
            end
        end
        assign nom[i] = valid[i] && !shadowed;
    end

endmodule

// File: rtl/row_sched_hit.sv
module row_sched_hit #(
    parameter int N_SLOT = 8,
    parameter int N_BANK = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic [N_SLOT*BANK_W-1:0] slot_bank,
    input  logic [N_SLOT*ROW_W-1:0]  slot_row,
    input  logic [N_BANK-1:0]        bank_open,
    input  logic [N_BANK*ROW_W-1:0]  bank_row,
    output logic [N_SLOT-1:0]        hit
);

    logic [ROW_W-1:0] open_rows [N_BANK];

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        assign open_rows[b] = bank_row[b*ROW_W +: ROW_W];
    end

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        logic [BANK_W-1:0] bk;
        assign bk     = slot_bank[i*BANK_W +: BANK_W];
        assign hit[i] = bank_open[bk] && (open_rows[bk] == slot_row[i*ROW_W +: ROW_W]);
    end

endmodule

// File: rtl/row_sched_pick.sv
module row_sched_pick
    import row_sched_pkg::*;
#(
    parameter int N_SLOT = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N_SLOT-1:0]        cand,
    input  logic [N_SLOT*PRIO_W-1:0] prio,
    output logic                     found,
    output logic [IDX_W-1:0]         idx
);

    prio_t best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N_SLOT; i++) begin
            if (cand[i] && (!found || prio_beats(prio[i*PRIO_W +: PRIO_W], best))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/row_sched_age.sv
module row_sched_age #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] limit,
    input  logic             taken,
    input  logic             taken_aged,
    output logic             due
);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (limit == '0) begin
            count <= '0;
        end else if (taken_aged) begin
            count <= '0;
        end else if (taken && (count < limit)) begin
            count <= count + 1'b1;
        end
    end

    assign due = (limit != '0) && (count >= limit);

endmodule

// File: rtl/row_sched.sv
module row_sched
    import row_sched_pkg::*;
#(
    parameter int N_SLOT   = 8,
    parameter int N_MASTER = 4,
    parameter int N_BANK   = 8,
    parameter int ROW_W    = 14,
    parameter int CNT_W    = 6,
    localparam int MID_W   = (N_MASTER > 1) ? $clog2(N_MASTER) : 1,
    localparam int BANK_W  = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    localparam int IDX_W   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_SLOT-1:0]          ent_valid,
    input  logic [N_SLOT*MID_W-1:0]    ent_master,
    input  logic [N_SLOT*PRIO_W-1:0]   ent_prio,
    input  logic [N_SLOT-1:0]          ent_write,
    input  logic [N_SLOT*BANK_W-1:0]   ent_bank,
    input  logic [N_SLOT*ROW_W-1:0]    ent_row,
    input  logic [N_BANK-1:0]          bank_open,
    input  logic [N_BANK*ROW_W-1:0]    bank_row,
    input  logic                       issue,
    input  logic [CNT_W-1:0]           promo_limit,
    output logic                       sel_valid,
    output logic [IDX_W-1:0]           sel_idx,
    output logic                       sel_write,
    output logic                       sel_hit,
    output logic                       sel_promoted
);

    logic [N_SLOT-1:0]        nom;
    logic [N_SLOT-1:0]        hit;
    logic [N_SLOT-1:0]        hit_nom;
    logic [N_SLOT*PRIO_W-1:0] flat_prio;
    logic                     hit_found, nom_found, old_found;
    logic [IDX_W-1:0]         hit_idx, nom_idx, old_idx;
    logic                     due;
    pick_e                    kind;

    assign flat_prio = '0;
    assign hit_nom   = hit & nom;

    row_sched_nominate #(.N_SLOT(N_SLOT), .MID_W(MID_W)) u_nominate (
        .valid  (ent_valid),
        .master (ent_master),
        .nom    (nom)
    );

    row_sched_hit #(.N_SLOT(N_SLOT), .N_BANK(N_BANK), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_hit (
        .slot_bank (ent_bank),
        .slot_row  (ent_row),
        .bank_open (bank_open),
        .bank_row  (bank_row),
        .hit       (hit)
    );

    row_sched_pick #(.N_SLOT(N_SLOT), .IDX_W(IDX_W)) u_pick_hit (
        .cand  (hit_nom),
        .prio  (ent_prio),
        .found (hit_found),
        .idx   (hit_idx)
    );

    row_sched_pick #(.N_SLOT(N_SLOT), .IDX_W(IDX_W)) u_pick_nom (
        .cand  (nom),
        .prio  (ent_prio),
        .found (nom_found),
        .idx   (nom_idx)
    );

    // flat priorities turn the arbiter into a lowest-index (oldest) finder
    row_sched_pick #(.N_SLOT(N_SLOT), .IDX_W(IDX_W)) u_pick_old (
        .cand  (ent_valid),
        .prio  (flat_prio),
        .found (old_found),
        .idx   (old_idx)
    );

    always_comb begin
        if (!old_found)      kind = PICK_NONE;
        else if (due)        kind = PICK_AGED;
        else if (hit_found)  kind = PICK_HIT;
        else if (nom_found)  kind = PICK_PRIO;
        else                 kind = PICK_NONE;
    end

    always_comb begin
        unique case (kind)
            PICK_AGED: sel_idx = old_idx;
            PICK_HIT:  sel_idx = hit_idx;
            PICK_PRIO: sel_idx = nom_idx;
            default:   sel_idx = '0;
        endcase
    end

    assign sel_valid    = (kind != PICK_NONE);
    assign sel_promoted = (kind == PICK_AGED);
    assign sel_write    = ent_write[sel_idx];
    assign sel_hit      = sel_valid && hit[sel_idx];

    row_sched_age #(.CNT_W(CNT_W)) u_age (
        .clk        (clk),
        .rst        (rst),
        .limit      (promo_limit),
        .taken      (issue && sel_valid),
        .taken_aged (issue && sel_promoted),
        .due        (due)
    );

endmodule

// File: rtl/row_sched_checker.sv
module row_sched_checker #(
    parameter int N_SLOT = 8,
    parameter int CNT_W  = 6,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [N_SLOT-1:0] ent_valid,
    input logic              issue,
    input logic [CNT_W-1:0]  promo_limit,
    input logic              sel_valid,
    input logic [IDX_W-1:0]  sel_idx,
    input logic              sel_hit,
    input logic              sel_promoted
);

    logic [N_SLOT-1:0] below_sel;
    assign below_sel = (N_SLOT'(1) << sel_idx) - N_SLOT'(1);

    a_r1_valid_needs_slot: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (ent_valid != '0));

    a_r1_slot_gives_valid: assert property (@(posedge clk) disable iff (rst)
        (ent_valid != '0) |-> sel_valid);

    a_r2_selected_is_valid: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> ent_valid[sel_idx]);

    a_r6_promoted_is_oldest: assert property (@(posedge clk) disable iff (rst)
        sel_promoted |-> ((ent_valid & below_sel) == '0));

    a_r7_clear_after_promo: assert property (@(posedge clk) disable iff (rst)
        (issue && sel_promoted) |=> !sel_promoted);

    a_r8_zero_limit_off: assert property (@(posedge clk) disable iff (rst)
        (promo_limit == '0) |-> !sel_promoted);

    a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        sel_hit |-> sel_valid);

    a_r10_no_promo_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !sel_promoted);

endmodule

bind row_sched row_sched_checker #(.N_SLOT(N_SLOT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .ent_valid    (ent_valid),
    .issue        (issue),
    .promo_limit  (promo_limit),
    .sel_valid    (sel_valid),
    .sel_idx      (sel_idx),
    .sel_hit      (sel_hit),
    .sel_promoted (sel_promoted)
);

// File: tb/row_sched_bench.sv
module row_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NM = 4;
    localparam int NB = 8;
    localparam int RW = 14;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          b_valid [NS];
    logic [1:0]    b_master[NS];
    logic [2:0]    b_prio  [NS];
    logic          b_write [NS];
    logic [2:0]    b_bank  [NS];
    logic [RW-1:0] b_row   [NS];
    logic          b_open  [NB];
    logic [RW-1:0] b_orow  [NB];
    logic          issue = 1'b0;
    logic [CW-1:0] lim = '0;

    logic [NS-1:0]    ent_valid, ent_write;
    logic [NS*2-1:0]  ent_master;
    logic [NS*3-1:0]  ent_prio, ent_bank;
    logic [NS*RW-1:0] ent_row;
    logic [NB-1:0]    bank_open;
    logic [NB*RW-1:0] bank_row;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            ent_valid[i]          = b_valid[i];
            ent_write[i]          = b_write[i];
            ent_master[i*2 +: 2]  = b_master[i];
            ent_prio[i*3 +: 3]    = b_prio[i];
            ent_bank[i*3 +: 3]    = b_bank[i];
            ent_row[i*RW +: RW]   = b_row[i];
        end
        for (int b = 0; b < NB; b++) begin
            bank_open[b]          = b_open[b];
            bank_row[b*RW +: RW]  = b_orow[b];
        end
    end

    logic       sel_valid, sel_write, sel_hit, sel_promoted;
    logic [2:0] sel_idx;

    row_sched #(.N_SLOT(NS), .N_MASTER(NM), .N_BANK(NB), .ROW_W(RW), .CNT_W(CW)) u_row_sched (
        .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_master(ent_master),
        .ent_prio(ent_prio), .ent_write(ent_write), .ent_bank(ent_bank), .ent_row(ent_row),
        .bank_open(bank_open), .bank_row(bank_row), .issue(issue), .promo_limit(lim),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_write(sel_write),
        .sel_hit(sel_hit), .sel_promoted(sel_promoted)
    );

    int errors = 0;
    int checks = 0;
    int mcnt = 0;
    logic e_valid, e_write, e_hit, e_prom;
    int   e_idx;
    bit   done = 0;

    function automatic void model();
        logic nom[NS];
        logic hit[NS];
        int best;
        e_valid = 1'b0; e_idx = 0; e_prom = 1'b0;
        for (int i = 0; i < NS; i++) begin
            nom[i] = b_valid[i];
            for (int j = 0; j < i; j++)
                if (b_valid[j] && b_master[j] == b_master[i]) nom[i] = 1'b0;
            hit[i] = b_open[b_bank[i]] && (b_orow[b_bank[i]] == b_row[i]);
        end
        for (int i = NS-1; i >= 0; i--)
            if (b_valid[i]) begin e_valid = 1'b1; e_idx = i; end
        if (e_valid && lim != 0 && mcnt >= int'(lim)) begin
            e_prom = 1'b1;
        end else if (e_valid) begin
            best = -1;
            for (int i = 0; i < NS; i++)
                if (nom[i] && hit[i] && (best < 0 || b_prio[i] < b_prio[best])) best = i;
            if (best < 0)
                for (int i = 0; i < NS; i++)
                    if (nom[i] && (best < 0 || b_prio[i] < b_prio[best])) best = i;
            e_idx = best;
        end
        e_write = b_write[e_idx];
        e_hit   = e_valid && hit[e_idx];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        model();
        chk({tag, " R1 sel_valid"}, sel_valid, e_valid);
        if (e_valid) begin
            chk({tag, " R2/R3/R4/R5 sel_idx"}, sel_idx, e_idx);
            chk({tag, " R9 sel_write"}, sel_write, e_write);
            chk({tag, " R9 sel_hit"}, sel_hit, e_hit);
        end
        chk({tag, " R6/R8 sel_promoted"}, sel_promoted, e_prom);
    endtask

    // check at mid-cycle, then advance one clock and update the count model
    task automatic step(input string tag);
        #1;
        check_all(tag);
        @(posedge clk);
        if (lim == 0) mcnt = 0;
        else if (issue && e_prom) mcnt = 0;
        else if (issue && e_valid && mcnt < int'(lim)) mcnt++;
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int i = 0; i < NS; i++) begin
            b_valid[i] = 0; b_master[i] = 0; b_prio[i] = 0;
            b_write[i] = 0; b_bank[i] = 0; b_row[i] = 0;
        end
        for (int b = 0; b < NB; b++) begin b_open[b] = 0; b_orow[b] = 0; end
    endtask

    task automatic put(input int i, input int m, input int p, input int w, input int bk, input int r);
        b_valid[i] = 1; b_master[i] = 2'(m); b_prio[i] = 3'(p);
        b_write[i] = 1'(w); b_bank[i] = 3'(bk); b_row[i] = RW'(r);
    endtask

    task automatic randomize_inputs();
        for (int i = 0; i < NS; i++) begin
            b_valid[i]  = ($urandom % 4) != 0;
            b_master[i] = 2'($urandom % NM);
            b_prio[i]   = 3'($urandom % 8);
            b_write[i]  = 1'($urandom % 2);
            b_bank[i]   = 3'($urandom % 4);
            b_row[i]    = RW'($urandom % 3);
        end
        for (int b = 0; b < NB; b++) begin
            b_open[b] = 1'($urandom % 2);
            b_orow[b] = RW'($urandom % 3);
        end
        issue = 1'($urandom % 2);
    endtask

    task automatic random_phase(input int l, input int n);
        lim = CW'(l);
        for (int k = 0; k < n; k++) begin
            randomize_inputs();
            step("random");
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        clear_all();
        lim = CW'(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1/R10 reset empty sel_valid", sel_valid, 0);
        put(0, 0, 7, 0, 0, 1);
        #1;
        chk("R10 reset promoted", sel_promoted, 0);
        rst = 1'b0;
        @(negedge clk);
        mcnt = 0;
        chk("R10 first cycle no promotion", sel_promoted, 0);
        step("R10 after reset");

        // R3: a low-priority hit beats a top-priority miss
        clear_all(); lim = 0; issue = 0;
        put(0, 0, 0, 0, 0, 1); b_open[0] = 1; b_orow[0] = 2;
        put(1, 1, 6, 0, 1, 3); b_open[1] = 1; b_orow[1] = 3;
        #1;
        chk("R3 hit over miss idx", sel_idx, 1);
        chk("R3 hit flag", sel_hit, 1);
        step("R3");

        // R4/R9: among hits, smallest priority, older on tie
        clear_all();
        b_open[2] = 1; b_orow[2] = 5;
        put(0, 0, 5, 0, 2, 5);
        put(1, 1, 2, 1, 2, 5);
        put(2, 2, 2, 0, 2, 5);
        #1;
        chk("R4 hit priority idx", sel_idx, 1);
        chk("R9 write flag", sel_write, 1);
        step("R4");

        // R2/R5: shadowed hit ignored, priority decides among misses
        clear_all();
        b_open[3] = 1; b_orow[3] = 9;
        put(0, 0, 7, 0, 4, 1);
        put(1, 0, 0, 0, 3, 9);
        put(2, 1, 4, 0, 5, 1);
        #1;
        chk("R2/R5 shadowed entry skipped", sel_idx, 2);
        chk("R2 no hit among candidates", sel_hit, 0);
        step("R2");
        b_prio[2] = 7;
        #1;
        chk("R5 tie goes to older", sel_idx, 0);
        step("R5");

        // R6/R7: promotion of slot-0 miss over a competing hit
        clear_all(); lim = 2; mcnt = 0; issue = 1;
        put(0, 0, 7, 0, 4, 1);
        put(1, 1, 0, 0, 6, 2); b_open[6] = 1; b_orow[6] = 2;
        #1; chk("R6 count0 no promo", sel_promoted, 0);
        step("R6 a");
        #1; chk("R6 count1 no promo", sel_promoted, 0);
        step("R6 b");
        #1;
        chk("R6 promoted", sel_promoted, 1);
        chk("R6 oldest idx", sel_idx, 0);
        step("R6 c");
        #1; chk("R7 cleared after promoted issue", sel_promoted, 0);
        chk("R7 back to hit", sel_idx, 1);
        step("R7");

        // R8: limit zero never promotes
        lim = 0;
        for (int k = 0; k < 10; k++) begin
            #1; chk("R8 zero limit", sel_promoted, 0);
            step("R8");
        end

        random_phase(3, 800);
        random_phase(0, 400);
        random_phase(1, 400);
        random_phase(7, 600);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule